// File: doc/BRIEF.md
# Receive Sample Phase Tuning Engine

This block chooses the receive sampling phase of a memory-card host interface without software stepping through the phases. It holds the clock-select register. The phase selector sits in the three lowest bits of that register, and the upper bits are a pass-through that the engine never alters. When a tuning request arrives, the engine sweeps all eight phases. At each phase it runs one tuning trial on an external command engine through a start/done/pass handshake, and it records each passing phase in an eight-bit candidate mask.

After the sweep, a scanner looks for a suitable phase in two passes. Both passes treat the phases as a ring. The first pass looks for a phase whose neighbourhood of five phases all passed. The second pass runs only if the first finds nothing, and it asks for a neighbourhood of three. The winning phase is written into the selector field and a one-cycle done pulse is raised. If no phase qualifies, an error flag is raised instead and the field is left as it was.

Top module: `phase_tune_engine`

## Requirements
- R1: While reset is high and after it, the engine is idle: `busy`, `trial_start`, `tmo_wr`, `tune_done` and `tune_err` are low, and `clksel` holds its reset value (default zero).
- R2: Each sweep step first moves the selector field (bits 2:0 of `clksel`) to (field + 1) mod 8, and only then runs a trial at the new phase.
- R3: A request clears the candidate mask. The sweep starts at the phase that was programmed when the request arrived, plus one. It ends after the trial at that starting phase, so exactly eight trials run, one per phase.
- R4: The cycle before each `trial_start`, `tmo_wr` is high with `tmo_wdata` all ones, which loads the data timeout with its maximum.
- R5: `trial_start` is a one-cycle pulse. The engine then waits for `trial_done` and takes `trial_pass` in the cycle where `trial_done` is high. A pass at phase p sets mask bit p.
- R6: First pass: the lowest i in 0..7 for which phases i-2, i-1, i, i+1 and i+2 (mod 8) all passed becomes the result.
- R7: Only when R6 finds nothing, the lowest i for which phases i-1, i and i+1 (mod 8) all passed becomes the result.
- R8: When neither pass finds a phase, `tune_err` is raised with the done pulse and the selector field keeps the value it had at the end of the sweep, which is the starting phase.
- R9: `tune_done` is high for exactly one cycle. In that cycle `clksel` already holds the final field, and `tune_err` is low on success.
- R10: A tuning request or a register load that arrives while `busy` is high is ignored.
- R11: Bits above the selector field change only through an idle register load. Tuning never modifies them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tune_start | input | 1 | Tuning request, accepted only when idle |
| sel_load | input | 1 | Load `sel_wdata` into the clock-select register when idle |
| sel_wdata | input | REG_W | Value to load into the clock-select register |
| clksel | output | REG_W | Clock-select register; bits 2:0 are the sample phase |
| sample_phase | output | 3 | Current sample phase (selector field) |
| tmo_wr | output | 1 | Data timeout load strobe |
| tmo_wdata | output | TMO_W | Data timeout value, all ones |
| trial_start | output | 1 | One-cycle start of a tuning trial |
| trial_done | input | 1 | Trial finished |
| trial_pass | input | 1 | Trial result, valid with `trial_done` |
| busy | output | 1 | Tuning in progress |
| tune_done | output | 1 | One-cycle end-of-tuning pulse |
| tune_err | output | 1 | No usable phase found; held until the next request |

## Verification
A trial starts one cycle after its timeout strobe. The field is already advanced in the `trial_start` cycle, so the trial phase is logged at the falling edge of that cycle. The mask bit lands on the edge that accepts `trial_done`. Scanning begins on the next cycle and tests one candidate per clock, which puts the done pulse between 1 and 16 cycles after the last `trial_done`. The bench therefore polls `tune_done` at every falling edge instead of counting a fixed delay, and it reads `clksel`, `tune_err` and the trial log in that same half cycle. On the falling edge after that, it confirms that the pulse has dropped.

// File: rtl/ptune_pkg.sv
package ptune_pkg;

    localparam int PHASE_W     = 3;
    localparam int NPH         = 1 << PHASE_W;
    localparam int WIDE_HALF   = 2;
    localparam int NARROW_HALF = 1;

    typedef logic [PHASE_W-1:0] phase_t;
    typedef logic [NPH-1:0]     mask_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_LAUNCH,
        ST_WAIT,
        ST_WIDE,
        ST_NARROW
    } state_e;

    localparam phase_t PH_LAST = phase_t'(NPH - 1);

    // Circular right rotation of the candidate mask.
    function automatic mask_t rot_right(mask_t m, phase_t n);
        mask_t lo;
        mask_t hi;
        lo = m >> n;
        hi = m << (NPH - int'(n));
        return lo | hi;
    endfunction

    // Bits of a rotated mask that must pass for a window of +/- half phases.
    function automatic mask_t span_mask(int half);
        mask_t m;
        m = '0;
        for (int k = 0; k < NPH; k++) begin
            if (k <= half || k >= NPH - half) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ptune_mask.sv
module ptune_mask
    import ptune_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   rec,
    input  logic   rec_pass,
    input  phase_t rec_phase,
    output mask_t  mask_q
);

    for (genvar b = 0; b < NPH; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                mask_q[b] <= 1'b0;
            end else if (rec && rec_pass && (rec_phase == phase_t'(b))) begin
                mask_q[b] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ptune_window.sv
module ptune_window
    import ptune_pkg::*;
(
    input  mask_t  mask,
    input  phase_t idx,
    output logic   hit_wide,
    output logic   hit_narrow
);

    localparam mask_t WIDE_NEED   = span_mask(WIDE_HALF);
    localparam mask_t NARROW_NEED = span_mask(NARROW_HALF);

    mask_t rot;

    always_comb begin
        rot        = rot_right(mask, idx);
        hit_wide   = ((rot & WIDE_NEED) == WIDE_NEED);
        hit_narrow = ((rot & NARROW_NEED) == NARROW_NEED);
    end

endmodule

// File: rtl/ptune_ctrl.sv
module ptune_ctrl
    import ptune_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tune_req,
    input  phase_t cur_phase,
    input  logic   trial_done,
    input  logic   hit_wide,
    input  logic   hit_narrow,
    output phase_t scan_idx,
    output logic   mask_clr,
    output logic   mask_rec,
    output logic   field_inc,
    output logic   field_wr,
    output logic   busy,
    output logic   tmo_wr,
    output logic   trial_start,
    output logic   tune_done,
    output logic   tune_err
);

    state_e st_q, st_d;
    phase_t idx_q, idx_d;
    phase_t home_q, home_d;
    logic   done_d, err_d;

    always_comb begin
        st_d        = st_q;
        idx_d       = idx_q;
        home_d      = home_q;
        done_d      = 1'b0;
        err_d       = tune_err;
        mask_clr    = 1'b0;
        mask_rec    = 1'b0;
        field_inc   = 1'b0;
        field_wr    = 1'b0;
        tmo_wr      = 1'b0;
        trial_start = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (tune_req) begin
                    mask_clr = 1'b1;
                    home_d   = cur_phase;
                    err_d    = 1'b0;
                    st_d     = ST_STEP;
                end
            end
            ST_STEP: begin
                field_inc = 1'b1;
                tmo_wr    = 1'b1;
                st_d      = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                trial_start = 1'b1;
                st_d        = ST_WAIT;
            end
            ST_WAIT: begin
                if (trial_done) begin
                    mask_rec = 1'b1;
                    if (cur_phase == home_q) begin
                        idx_d = '0;
                        st_d  = ST_WIDE;
                    end else begin
                        st_d  = ST_STEP;
                    end
                end
            end
            ST_WIDE: begin
                if (hit_wide) begin
                    field_wr = 1'b1;
                    done_d   = 1'b1;
                    st_d     = ST_IDLE;
                end else if (idx_q == PH_LAST) begin
                    idx_d = '0;
                    st_d  = ST_NARROW;
                end else begin
                    idx_d = phase_t'(idx_q + 1'b1);
                end
            end
            ST_NARROW: begin
                if (hit_narrow) begin
                    field_wr = 1'b1;
                    done_d   = 1'b1;
                    st_d     = ST_IDLE;
                end else if (idx_q == PH_LAST) begin
                    err_d  = 1'b1;
                    done_d = 1'b1;
                    st_d   = ST_IDLE;
                end else begin
                    idx_d = phase_t'(idx_q + 1'b1);
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            idx_q     <= '0;
            home_q    <= '0;
            tune_done <= 1'b0;
            tune_err  <= 1'b0;
        end else begin
            st_q      <= st_d;
            idx_q     <= idx_d;
            home_q    <= home_d;
            tune_done <= done_d;
            tune_err  <= err_d;
        end
    end

    assign busy     = (st_q != ST_IDLE);
    assign scan_idx = idx_q;

endmodule

// File: rtl/phase_tune_engine.sv
module phase_tune_engine
    import ptune_pkg::*;
#(
    parameter int               REG_W     = 8,
    parameter int               TMO_W     = 16,
    parameter logic [REG_W-1:0] SEL_RESET = '0
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               tune_start,
    input  logic               sel_load,
    input  logic [REG_W-1:0]   sel_wdata,
    output logic [REG_W-1:0]   clksel,
    output logic [PHASE_W-1:0] sample_phase,
    output logic               tmo_wr,
    output logic [TMO_W-1:0]   tmo_wdata,
    output logic               trial_start,
    input  logic               trial_done,
    input  logic               trial_pass,
    output logic               busy,
    output logic               tune_done,
    output logic               tune_err
);

    logic [REG_W-1:0] clksel_q;
    phase_t           field;
    phase_t           scan_idx;
    mask_t            mask_q;
    logic             mask_clr, mask_rec, field_inc, field_wr;
    logic             hit_wide, hit_narrow;

    assign field = clksel_q[PHASE_W-1:0];

    ptune_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .tune_req    (tune_start),
        .cur_phase   (field),
        .trial_done  (trial_done),
        .hit_wide    (hit_wide),
        .hit_narrow  (hit_narrow),
        .scan_idx    (scan_idx),
        .mask_clr    (mask_clr),
        .mask_rec    (mask_rec),
        .field_inc   (field_inc),
        .field_wr    (field_wr),
        .busy        (busy),
        .tmo_wr      (tmo_wr),
        .trial_start (trial_start),
        .tune_done   (tune_done),
        .tune_err    (tune_err)
    );

    ptune_mask u_mask (
        .clk       (clk),
        .rst       (rst),
        .clr       (mask_clr),
        .rec       (mask_rec),
        .rec_pass  (trial_pass),
        .rec_phase (field),
        .mask_q    (mask_q)
    );

    ptune_window u_window (
        .mask       (mask_q),
        .idx        (scan_idx),
        .hit_wide   (hit_wide),
        .hit_narrow (hit_narrow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            clksel_q <= SEL_RESET;
        end else if (sel_load && !busy) begin
            clksel_q <= sel_wdata;
        end else if (field_inc) begin
            clksel_q[PHASE_W-1:0] <= phase_t'(field + 1'b1);
        end else if (field_wr) begin
            clksel_q[PHASE_W-1:0] <= scan_idx;
        end
    end

    assign clksel       = clksel_q;
    assign sample_phase = field;
    assign tmo_wdata    = '1;

endmodule

// File: rtl/ptune_checker.sv
module ptune_checker
    import ptune_pkg::*;
#(
    parameter int REG_W = 8
)(
    input logic             clk,
    input logic             rst,
    input logic             sel_load,
    input logic [REG_W-1:0] clksel,
    input logic             trial_start,
    input logic             tmo_wr,
    input logic             tune_done,
    input logic             tune_err
);

    // R4: the timeout load precedes every trial launch by one cycle
    p_tmo_then_trial_r4: assert property (@(posedge clk) disable iff (rst)
        tmo_wr |=> trial_start);

    // R2: the phase seen at launch is the previous phase plus one, mod 8
    p_step_advance_r2: assert property (@(posedge clk) disable iff (rst)
        trial_start |-> (clksel[PHASE_W-1:0] == phase_t'($past(clksel[PHASE_W-1:0]) + 1'b1)));

    // R5: trial start is a single-cycle pulse
    p_trial_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        trial_start |=> !trial_start);

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        tune_done |=> !tune_done);

    // R8: on failure the selector field is not rewritten
    p_err_keeps_field_r8: assert property (@(posedge clk) disable iff (rst)
        (tune_done && tune_err) |-> $stable(clksel[PHASE_W-1:0]));

    // R11: upper register bits move only through a load
    p_upper_kept_r11: assert property (@(posedge clk) disable iff (rst)
        !sel_load |=> $stable(clksel[REG_W-1:PHASE_W]));

endmodule

bind phase_tune_engine ptune_checker #(.REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel_load    (sel_load),
    .clksel      (clksel),
    .trial_start (trial_start),
    .tmo_wr      (tmo_wr),
    .tune_done   (tune_done),
    .tune_err    (tune_err)
);

// File: tb/phase_tune_engine_tb.sv
module phase_tune_engine_tb;

    localparam int REG_W = 8;
    localparam int TMO_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tune_start = 1'b0;
    logic             sel_load = 1'b0;
    logic [REG_W-1:0] sel_wdata = '0;
    logic [REG_W-1:0] clksel;
    logic [2:0]       sample_phase;
    logic             tmo_wr;
    logic [TMO_W-1:0] tmo_wdata;
    logic             trial_start;
    logic             trial_done = 1'b0;
    logic             trial_pass = 1'b0;
    logic             busy;
    logic             tune_done;
    logic             tune_err;

    phase_tune_engine #(.REG_W(REG_W), .TMO_W(TMO_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .tune_start   (tune_start),
        .sel_load     (sel_load),
        .sel_wdata    (sel_wdata),
        .clksel       (clksel),
        .sample_phase (sample_phase),
        .tmo_wr       (tmo_wr),
        .tmo_wdata    (tmo_wdata),
        .trial_start  (trial_start),
        .trial_done   (trial_done),
        .trial_pass   (trial_pass),
        .busy         (busy),
        .tune_done    (tune_done),
        .tune_err     (tune_err)
    );

    always #4 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] pattern = '0;
    int         n_trials = 0;
    int         n_tmo    = 0;
    int         tmo_bad  = 0;
    logic [2:0] trial_log [16];

    // {init register, pass pattern, expected phase, expected error}
    localparam logic [19:0] VEC [8] = '{
        {8'h00, 8'hFF, 3'd0, 1'b0},   // R6 all pass
        {8'hA5, 8'h3E, 3'd3, 1'b0},   // R6 centre of 1..5, R11 upper bits
        {8'h12, 8'hE3, 3'd7, 1'b0},   // R6 window wrapping through 0
        {8'h07, 8'h0E, 3'd2, 1'b0},   // R7 only three in a row
        {8'hF0, 8'hC1, 3'd7, 1'b0},   // R7 wrapping window
        {8'h3C, 8'h55, 3'd4, 1'b1},   // R8 alternate passes
        {8'h01, 8'h00, 3'd1, 1'b1},   // R8 nothing passes
        {8'h66, 8'h7C, 3'd4, 1'b0}    // R6 centre of 2..6
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Card-side responder: variable latency, pass taken from pattern
    initial begin
        forever begin
            @(negedge clk);
            if (trial_start) begin
                logic [2:0] ph;
                ph = sample_phase;
                if (n_trials < 16) trial_log[n_trials] = ph;
                repeat ((n_trials % 3) + 1) @(negedge clk);
                trial_done = 1'b1;
                trial_pass = pattern[ph];
                n_trials++;
                @(negedge clk);
                trial_done = 1'b0;
                trial_pass = 1'b0;
            end
        end
    end

    // Timeout strobe monitor
    initial begin
        forever begin
            @(negedge clk);
            if (tmo_wr) begin
                n_tmo++;
                if (tmo_wdata != '1) tmo_bad++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic run_tune(input logic [7:0] init, input logic [7:0] pat,
                            input logic [2:0] exp_ph, input logic exp_err,
                            input bit poke);
        int waited;
        @(negedge clk);
        sel_load  = 1'b1;
        sel_wdata = init;
        @(negedge clk);
        sel_load = 1'b0;
        pattern  = pat;
        n_trials = 0;
        n_tmo    = 0;
        tmo_bad  = 0;
        tune_start = 1'b1;
        @(negedge clk);
        tune_start = 1'b0;
        waited = 0;
        while (!tune_done && waited < 2000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 10) begin
                tune_start = 1'b1;            // R10 request while busy
                sel_load   = 1'b1;
                sel_wdata  = 8'h00;
            end else if (poke && waited == 11) begin
                tune_start = 1'b0;
                sel_load   = 1'b0;
            end
        end
        check(tune_done, "R9 done seen", int'(tune_done), 1);
        check(clksel[2:0] == exp_ph, "R6/R7/R8 chosen phase", int'(clksel[2:0]), int'(exp_ph));
        check(tune_err == exp_err, "R8 error flag", int'(tune_err), int'(exp_err));
        check(clksel[7:3] == init[7:3], "R11 upper bits kept", int'(clksel[7:3]), int'(init[7:3]));
        check(n_trials == 8, "R3 trial count", n_trials, 8);
        check(n_tmo == 8 && tmo_bad == 0, "R4 timeout loads", n_tmo, 8);
        check(trial_log[0] == 3'(init[2:0] + 3'd1), "R2 first trial phase", int'(trial_log[0]), int'(3'(init[2:0] + 3'd1)));
        check(trial_log[7] == init[2:0], "R3 last trial at start phase", int'(trial_log[7]), int'(init[2:0]));
        for (int k = 1; k < 8; k++) begin
            check(trial_log[k] == 3'(trial_log[k-1] + 3'd1), "R2 sweep order",
                  int'(trial_log[k]), int'(3'(trial_log[k-1] + 3'd1)));
        end
        @(negedge clk);
        check(!tune_done, "R9 done one cycle", int'(tune_done), 0);
        check(!busy, "R10 idle after done", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !trial_start && !tmo_wr, "R1 idle in reset", int'(busy), 0);
        check(!tune_done && !tune_err, "R1 flags clear", int'(tune_done), 0);
        check(clksel == '0, "R1 register reset", int'(clksel), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !trial_start, "R1 idle after reset", int'(busy), 0);

        for (int v = 0; v < 8; v++) begin
            run_tune(VEC[v][19:12], VEC[v][11:4], VEC[v][3:1], VEC[v][0], 1'b0);
        end

        // R3: mask cleared at start; passing sweep after a failing one
        run_tune(8'h01, 8'h00, 3'd1, 1'b1, 1'b0);
        run_tune(8'h01, 8'hF8, 3'd5, 1'b0, 1'b0);

        // R10: request and load during tuning are ignored
        run_tune(8'hB3, 8'h1F, 3'd2, 1'b0, 1'b1);

        // R1: reset in the middle of a sweep returns to idle
        pattern = 8'hFF;
        @(negedge clk);
        tune_start = 1'b1;
        @(negedge clk);
        tune_start = 1'b0;
        repeat (6) @(negedge clk);
        check(busy, "R1 busy mid sweep", int'(busy), 1);
        rst = 1'b1;
        @(negedge clk);
        check(!busy && !tune_done && clksel == '0, "R1 reset mid sweep", int'(busy), 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check(!busy && !trial_start, "R1 stays idle", int'(busy), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule